// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block sits between a host that issues single-word reads and writes and a 64K x 4 dynamic memory whose address pins are shared between row and column. Each host address is 16 bits wide. The block splits it into two 8-bit halves. The upper half is driven on the shared pins and latched by the memory when the row strobe falls. The lower half follows and is latched when the column strobe falls. Both strobes and the write strobe are active low.

Stored charge in the array leaks away within a millisecond. A free-running interval timer therefore raises a refresh request 256 times per millisecond. For each request the controller runs a row-only strobe cycle on the next row of an 8-bit sweep counter. An arbiter serves a pending refresh before any new host request. It never cuts short a host access that has already started.

On the host side, a request is held until a single-cycle ready pulse marks completion. On a read, that pulse also marks valid read data. All timing intervals are counted in controller clock cycles and are set through parameters.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the row, column and write strobes are high (inactive), ready is low, the data drive enable is low and the read data output is zero.
- R2: A host access drives address bits [15:8] on the shared pins when the row strobe falls, and keeps them there until the column strobe falls.
- R3: The column strobe falls exactly RCD_CYC cycles after the row strobe fell. At that moment the pins carry address bits [7:0].
- R4: The column strobe stays low for exactly CAS_CYC cycles, and both strobes return high on the same edge. The row strobe stays high for at least PRE_CYC cycles before it falls again.
- R5: On a write, the write strobe is low exactly while the column strobe is low, and the data bus is driven with the request's write data. On a read, the write strobe stays high throughout the access.
- R6: Ready is high for exactly one cycle per accepted request. On a read, the read data output in that cycle equals the 4-bit word stored at the addressed cell.
- R7: A refresh cycle keeps the column and write strobes high. It drives the refresh row on the pins and holds the row strobe low for RAS_REF_CYC cycles.
- R8: The refresh row starts at 0 after reset, advances by one after each refresh, and wraps from 255 to 0.
- R9: With no host traffic, consecutive refresh row-strobe falls are exactly REF_INTERVAL cycles apart. A refresh request is kept pending until it is served.
- R10: Under back-to-back host requests, refreshes continue to be served. The gap between refresh row-strobe falls never exceeds REF_INTERVAL plus one full host access. A host access is never interrupted by a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 4 | Read data, valid with ready |
| mem_addr | output | 8 | Shared row/column address pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 4 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_in | input | 4 | Data returned by the memory |

## Verification
A corrupted sequencer state shows up at the pins within a single cycle. It appears as a wrong strobe width, a strobe pattern out of order, or the wrong address half at a strobe fall. A broken refresh row counter is caught at the very next refresh, because every refresh row is compared with an independently tracked sweep. A refresh request that is lost, or an arbiter that favours the host, only becomes visible as a refresh gap longer than one interval plus one host access. Under saturated host traffic that gap is bounded, so the fault is reported within about one interval.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACT_ROW,
        S_ACT_RAS,
        S_ACT_CAS,
        S_PRE,
        S_REF_ROW,
        S_REF_RAS
    } seq_state_e;

    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REF
    } pin_sel_e;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int REF_INTERVAL = 781,
    parameter int ROW_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_served,
    output logic             ref_tick,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0]    cnt;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t q, n;

    always_comb begin
        n = q;
        if (q.cnt == LAST) begin
            n.cnt = '0;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
        if (ref_served) begin
            n.row = q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign ref_tick = (q.cnt == LAST);
    assign ref_row  = q.row;

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  pin_sel_e         sel,
    input  logic [ROW_W-1:0] host_row,
    input  logic [ROW_W-1:0] host_col,
    input  logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] pins
);
    always_comb begin
        unique case (sel)
            PIN_COL: pins = host_col;
            PIN_REF: pins = ref_row;
            default: pins = host_row;
        endcase
    end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 4,
    parameter int RCD_CYC     = 2,
    parameter int CAS_CYC     = 2,
    parameter int PRE_CYC     = 2,
    parameter int RAS_REF_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                ref_tick,
    output logic                ref_served,
    output pin_sel_e            pin_sel,
    output logic [ADDR_W/2-1:0] host_row,
    output logic [ADDR_W/2-1:0] host_col,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    input  logic [DATA_W-1:0]   dq_in
);
    localparam int ROW_W  = ADDR_W / 2;
    localparam int M1     = (RCD_CYC > CAS_CYC) ? RCD_CYC : CAS_CYC;
    localparam int M2     = (PRE_CYC > RAS_REF_CYC) ? PRE_CYC : RAS_REF_CYC;
    localparam int CYC_MX = (M1 > M2) ? M1 : M2;
    localparam int CNT_W  = $clog2(CYC_MX + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              pending;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ready;
    } seq_t;

    seq_t q, n;

    always_comb begin
        n          = q;
        n.ready    = 1'b0;
        n.pending  = q.pending | ref_tick;
        ref_served = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (q.pending) begin
                    n.state   = S_REF_ROW;
                    n.pending = ref_tick;
                end else if (req_valid) begin
                    n.state = S_ACT_ROW;
                    n.addr  = req_addr;
                    n.we    = req_we;
                    n.wdata = req_wdata;
                end
            end
            S_ACT_ROW: begin
                n.state = S_ACT_RAS;
                n.cnt   = CNT_W'(RCD_CYC - 1);
            end
            S_ACT_RAS: begin
                if (q.cnt == '0) begin
                    n.state = S_ACT_CAS;
                    n.cnt   = CNT_W'(CAS_CYC - 1);
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            S_ACT_CAS: begin
                if (q.cnt == '0) begin
                    n.state = S_PRE;
                    n.cnt   = CNT_W'(PRE_CYC - 1);
                    n.ready = 1'b1;
                    if (!q.we) begin
                        n.rdata = dq_in;
                    end
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            S_PRE: begin
                if (q.cnt == '0) begin
                    n.state = S_IDLE;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            S_REF_ROW: begin
                n.state = S_REF_RAS;
                n.cnt   = CNT_W'(RAS_REF_CYC - 1);
            end
            S_REF_RAS: begin
                if (q.cnt == '0) begin
                    n.state    = S_PRE;
                    n.cnt      = CNT_W'(PRE_CYC - 1);
                    ref_served = 1'b1;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            default: n.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        unique case (q.state)
            S_ACT_CAS:            pin_sel = PIN_COL;
            S_REF_ROW, S_REF_RAS: pin_sel = PIN_REF;
            default:              pin_sel = PIN_ROW;
        endcase
    end

    assign ras_n     = !(q.state inside {S_ACT_RAS, S_ACT_CAS, S_REF_RAS});
    assign cas_n     = (q.state != S_ACT_CAS);
    assign we_n      = !((q.state == S_ACT_CAS) && q.we);
    assign dq_oe     = (q.state == S_ACT_CAS) && q.we;
    assign dq_out    = q.wdata;
    assign host_row  = q.addr[ADDR_W-1 -: ROW_W];
    assign host_col  = q.addr[ROW_W-1:0];
    assign req_ready = q.ready;
    assign rd_data   = q.rdata;

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 4,
    parameter int REF_INTERVAL = 781,
    parameter int RCD_CYC      = 2,
    parameter int CAS_CYC      = 2,
    parameter int PRE_CYC      = 2,
    parameter int RAS_REF_CYC  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W/2-1:0] mem_addr,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_we_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    localparam int ROW_W = ADDR_W / 2;

    logic             ref_tick;
    logic             ref_served;
    logic [ROW_W-1:0] ref_row;
    logic [ROW_W-1:0] host_row;
    logic [ROW_W-1:0] host_col;
    pin_sel_e         pin_sel;

    dram_refresh_timer #(
        .REF_INTERVAL (REF_INTERVAL),
        .ROW_W        (ROW_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_served (ref_served),
        .ref_tick   (ref_tick),
        .ref_row    (ref_row)
    );

    dram_seq #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .RCD_CYC     (RCD_CYC),
        .CAS_CYC     (CAS_CYC),
        .PRE_CYC     (PRE_CYC),
        .RAS_REF_CYC (RAS_REF_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rd_data    (rd_data),
        .ref_tick   (ref_tick),
        .ref_served (ref_served),
        .pin_sel    (pin_sel),
        .host_row   (host_row),
        .host_col   (host_col),
        .ras_n      (mem_ras_n),
        .cas_n      (mem_cas_n),
        .we_n       (mem_we_n),
        .dq_out     (mem_dq_out),
        .dq_oe      (mem_dq_oe),
        .dq_in      (mem_dq_in)
    );

    dram_addr_mux #(
        .ROW_W (ROW_W)
    ) u_mux (
        .sel      (pin_sel),
        .host_row (host_row),
        .host_col (host_col),
        .ref_row  (ref_row),
        .pins     (mem_addr)
    );

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
    parameter int ROW_W        = 8,
    parameter int REF_INTERVAL = 781,
    parameter int RCD_CYC      = 2,
    parameter int CAS_CYC      = 2,
    parameter int PRE_CYC      = 2,
    parameter int RAS_REF_CYC  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_ras_n,
    input logic             mem_cas_n,
    input logic             mem_we_n,
    input logic             mem_dq_oe,
    input logic [ROW_W-1:0] mem_addr
);
    localparam int HOST_LEN = 1 + RCD_CYC + CAS_CYC + PRE_CYC + 1;
    localparam int GAP_MAX  = REF_INTERVAL + 2 * HOST_LEN + RAS_REF_CYC + 4;
    localparam int GW       = $clog2(GAP_MAX + 2);

    logic          ras_prev_q;
    logic [GW-1:0] gap_q;
    logic          ref_fall;

    assign ref_fall = ras_prev_q && !mem_ras_n && mem_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_prev_q <= 1'b1;
            gap_q      <= '0;
        end else begin
            ras_prev_q <= mem_ras_n;
            if (ref_fall) begin
                gap_q <= '0;
            end else if (gap_q != GW'(GAP_MAX + 1)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R6
    ready_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(!mem_cas_n));

    // R7
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> !mem_ras_n);

    // R5
    we_inside_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cas_n);

    // R5
    drive_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ras_n && $past(!mem_ras_n) && mem_cas_n && $past(mem_cas_n))
        |-> $stable(mem_addr));

    // R3
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_addr));

    // R10
    refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(GAP_MAX));

endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(
    .ROW_W        (ADDR_W / 2),
    .REF_INTERVAL (REF_INTERVAL),
    .RCD_CYC      (RCD_CYC),
    .CAS_CYC      (CAS_CYC),
    .PRE_CYC      (PRE_CYC),
    .RAS_REF_CYC  (RAS_REF_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/tb_dram_mux_ctrl.sv
`timescale 1ns/1ps
module tb_dram_mux_ctrl;
    localparam int AW    = 16;
    localparam int DW    = 4;
    localparam int INTV  = 40;
    localparam int RCD   = 2;
    localparam int CASC  = 2;
    localparam int PRE   = 2;
    localparam int RREF  = 3;
    localparam int BOUND = INTV + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rd_data;
    logic [7:0]    mem_addr;
    logic          mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    always #2.5 clk = ~clk;

    dram_mux_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .REF_INTERVAL (INTV),
        .RCD_CYC (RCD), .CAS_CYC (CASC), .PRE_CYC (PRE), .RAS_REF_CYC (RREF)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
        .rd_data (rd_data), .mem_addr (mem_addr), .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n), .mem_we_n (mem_we_n), .mem_dq_out (mem_dq_out),
        .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural memory, indexed by row[3:0],col[3:0]
    logic [DW-1:0] mem_m [256];
    logic [DW-1:0] exp_m [256];
    logic [7:0]    row_l = '0;
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] cur_wdata = '0;
    bit            cur_we = 1'b0;
    bit            prev_ras = 1'b1, prev_cas = 1'b1;
    bit            cas_seen = 1'b0, we_seen = 1'b0, wrap_seen = 1'b0;
    int            ras_low_n = 0, cas_low_n = 0, ras_high_n = 100;
    int            cyc = 0, fall_cyc = 0, last_ref_fall = 0;
    int            ref_count = 0, last_gap = 0, max_gap = 0;
    logic [7:0]    exp_ref = '0;
    logic [7:0]    last_ref_row = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = '0;
            exp_m[i] = '0;
        end
    end

    always_comb mem_dq_in = !mem_cas_n ? mem_m[{row_l[3:0], mem_addr[3:0]}] : '0;

    always @(posedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_cas_n && mem_ras_n) chk(0, "R7 CAS low outside RAS", 0, 1);
            if (!mem_ras_n) begin
                if (prev_ras) begin
                    chk(ras_high_n >= PRE, "R4 precharge", ras_high_n, PRE);
                    row_l = mem_addr; ras_low_n = 0; cas_seen = 0; we_seen = 0;
                    fall_cyc = cyc;
                end
                ras_low_n++;
                if (mem_cas_n) begin
                    if (!mem_we_n) chk(0, "R5 WE without CAS", 0, 1);
                    if (!cas_seen && mem_addr != row_l) chk(0, "R2 row held", mem_addr, row_l);
                end else begin
                    if (prev_cas) begin
                        chk(ras_low_n - 1 == RCD, "R3 RAS to CAS", ras_low_n - 1, RCD);
                        chk(row_l == cur_addr[15:8], "R2 row half", row_l, cur_addr[15:8]);
                        chk(mem_addr == cur_addr[7:0], "R3 column half", mem_addr, cur_addr[7:0]);
                        if (cur_we) begin
                            chk(!mem_we_n && mem_dq_oe && mem_dq_out == cur_wdata,
                                "R5 write drive", mem_dq_out, cur_wdata);
                            mem_m[{row_l[3:0], mem_addr[3:0]}] = mem_dq_out;
                        end
                        cas_seen = 1; cas_low_n = 0;
                    end
                    cas_low_n++;
                    if (!mem_we_n) we_seen = 1;
                end
            end else if (!prev_ras) begin
                ras_high_n = 1;
                if (cas_seen) begin
                    chk(ras_low_n == RCD + CASC, "R4 RAS width", ras_low_n, RCD + CASC);
                    chk(cas_low_n == CASC, "R4 CAS width", cas_low_n, CASC);
                    chk(mem_cas_n, "R4 strobes rise together", mem_cas_n, 1);
                    if (!cur_we) chk(!we_seen, "R5 WE high on read", we_seen, 0);
                end else begin
                    chk(ras_low_n == RREF, "R7 refresh RAS width", ras_low_n, RREF);
                    chk(row_l == exp_ref, "R8 refresh row", row_l, exp_ref);
                    if (ref_count > 0 && last_ref_row == 8'd255 && row_l == 8'd0) wrap_seen = 1;
                    last_ref_row = row_l;
                    exp_ref = exp_ref + 8'd1;
                    if (ref_count > 0) begin
                        last_gap = fall_cyc - last_ref_fall;
                        if (last_gap > max_gap) max_gap = last_gap;
                    end
                    last_ref_fall = fall_cyc;
                    ref_count++;
                end
            end else begin
                ras_high_n++;
            end
            prev_ras = mem_ras_n;
            prev_cas = mem_cas_n;
        end
    end

    task automatic do_access(input bit we, input logic [AW-1:0] addr,
                             input logic [DW-1:0] wdata, output logic [DW-1:0] rdata);
        int n;
        @(negedge clk);
        cur_addr = addr; cur_we = we; cur_wdata = wdata;
        req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wdata;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!req_ready && n < 200);
        chk(req_ready, "R6 ready arrives", req_ready, 1);
        rdata = rd_data;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ready, "R6 ready single cycle", req_ready, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_ras_n && mem_cas_n && mem_we_n, "R1 strobes in reset",
            {mem_ras_n, mem_cas_n, mem_we_n}, 7);
        chk(!req_ready && !mem_dq_oe, "R1 ready/oe in reset", {req_ready, mem_dq_oe}, 0);
        chk(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ras_n && mem_cas_n && !req_ready, "R1 after release",
            {mem_ras_n, mem_cas_n, req_ready}, 6);
    endtask

    task automatic t_write_read();
        logic [AW-1:0] al [6];
        logic [DW-1:0] rd;
        al[0] = 16'h0000; al[1] = 16'hFFFF; al[2] = 16'h12A5;
        al[3] = 16'hA512; al[4] = 16'h00FF; al[5] = 16'hFF00;
        foreach (al[i]) begin
            do_access(1'b1, al[i], DW'(i + 3), rd);
            exp_m[{al[i][11:8], al[i][3:0]}] = DW'(i + 3);
        end
        foreach (al[i]) begin
            do_access(1'b0, al[i], '0, rd);
            chk(rd == exp_m[{al[i][11:8], al[i][3:0]}], "R6 read data", rd,
                exp_m[{al[i][11:8], al[i][3:0]}]);
        end
    endtask

    task automatic t_idle_refresh();
        int start;
        start = ref_count;
        for (int k = 0; k < 4; k++) begin
            int c;
            c = ref_count;
            while (ref_count == c) @(negedge clk);
            if (k > 0) chk(last_gap == INTV, "R9 idle refresh spacing", last_gap, INTV);
        end
        chk(ref_count - start == 4, "R9 refreshes served", ref_count - start, 4);
    endtask

    task automatic t_saturate();
        logic [DW-1:0] rd;
        int start;
        max_gap = 0;
        start = ref_count;
        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] a;
            a = {4'h5, 4'(k), 4'h6, 4'(k >> 1)};
            if (k % 2 == 0) begin
                do_access(1'b1, a, DW'(k ^ 5), rd);
                exp_m[{a[11:8], a[3:0]}] = DW'(k ^ 5);
            end else begin
                do_access(1'b0, a, '0, rd);
                chk(rd == exp_m[{a[11:8], a[3:0]}], "R6 read under load", rd,
                    exp_m[{a[11:8], a[3:0]}]);
            end
        end
        chk(ref_count - start >= 2, "R10 refresh not starved", ref_count - start, 2);
        chk(max_gap <= BOUND, "R10 refresh gap under load", max_gap, BOUND);
    endtask

    task automatic t_wrap();
        while (!wrap_seen && ref_count < 300) @(negedge clk);
        chk(wrap_seen, "R8 row counter wraps 255 to 0", wrap_seen, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_idle_refresh();
        t_saturate();
        t_wrap();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule